// File: doc/BRIEF.md
# Glitch-Free Gated Clock Output Bank

This block takes one free-running source clock and produces a bank of gated copies of it, one per output. Each output has two enables: a hardware pin that may change at any time, and an enable bit held in a configuration register. The output runs only while both are high. Dropping either one stops that output cleanly, with the line parked low. The source clock and every other output keep running.

The two enables are combined first. The combined enable then goes through a synchroniser clocked by the source. A flop clocked on the falling edge of the source finally opens or closes the gate. The gate can therefore change state only while the source is low. Every pulse on a gated output is a whole source pulse: none is cut short and none is stretched. After the enable is asserted, the first output edge comes within a fixed, small number of source cycles. The default configuration has five outputs, which covers four differential clocks and one reference clock.

Top module: `ckg_bank`

## Requirements
- R1: While `rst` is high, every `clk_out` bit stays low. After `rst` is released, the first rising edge on an output whose enables are both high comes exactly 3 source periods after the release, counting from a release driven just after a source rising edge.
- R2: `clk_out[i]` toggles only while `hw_en[i]` and `sw_en[i]` are both high. All four combinations of the two bits are honoured independently on every output.
- R3: If `hw_en[i]` falls while `sw_en[i]` is high, `clk_out[i]` delivers exactly 2 more rising edges and then stops.
- R4: If `sw_en[i]` falls while `hw_en[i]` is high, `clk_out[i]` delivers exactly 2 more rising edges and then stops.
- R5: A stopped output is held at logic low. While running, an output is low whenever the source clock is low.
- R6: Every high pulse on an output lasts exactly one source high phase. Every low interval lasts one source low phase plus a whole number of source periods, so no runt or stretched pulse is ever produced.
- R7: When the combined enable rises, the first output rising edge comes on the third source rising edge after the change. That is two source cycles after the first edge that samples it, which lies inside the 2 to 6 cycle bound.
- R8: Starting or stopping one output has no effect on the pulse train of any other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset; closes every gate |
| hw_en | input | N_OUT | Per-output enable pins, asynchronous, active high |
| sw_en | input | N_OUT | Per-output register enable bits, active high |
| clk_out | output | N_OUT | Gated clock outputs, low when stopped |

## Verification
The two events that can meet in one cycle are a change of enable and a gate transition. On another output, they are a change of enable and a pulse already in flight. The bench sweeps all 1024 combinations of the ten enable bits, so that outputs start and stop in the same cycle while their neighbours keep running. Each output's count of rising edges in a settled window is compared with the AND of its own two bits. Meanwhile, monitors time every high pulse and every low interval on every output against the source period. Separate directed runs drop one enable of a running output and time the last pulses, then reassert it and time the first one.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  // Fewest synchroniser stages that still resolve an asynchronous enable.
  localparam int unsigned CKG_MIN_STAGES = 2;

  // Source periods from an enable sampled on a falling edge to the high phase
  // it controls: one per synchroniser stage plus the falling-edge gate flop.
  function automatic int unsigned ckg_restart_lag(input int unsigned stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
  input  logic clk,
  input  logic rst,
  input  logic en_sync,
  output logic clk_gated
);
  logic open_q;

  // Updated only on the falling edge, so the gate moves while clk is low.
  always_ff @(negedge clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= en_sync;
  end

  assign clk_gated = clk & open_q;
endmodule

// File: rtl/ckg_channel.sv
module ckg_channel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst,
  input  logic hw_en,
  input  logic sw_en,
  output logic clk_out
);
  logic want;
  logic want_s;

  assign want = hw_en & sw_en;

  ckg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_src),
    .rst (rst),
    .d   (want),
    .q   (want_s)
  );

  ckg_gate u_gate (
    .clk       (clk_src),
    .rst       (rst),
    .en_sync   (want_s),
    .clk_gated (clk_out)
  );
endmodule

// File: rtl/ckg_bank.sv
module ckg_bank
  import ckg_pkg::*;
#(
  parameter int unsigned N_OUT       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_src,
  input  logic             rst,
  input  logic [N_OUT-1:0] hw_en,
  input  logic [N_OUT-1:0] sw_en,
  output logic [N_OUT-1:0] clk_out
);
  if (SYNC_STAGES < CKG_MIN_STAGES) begin : g_bad_cfg
    $error("ckg_bank: SYNC_STAGES below minimum");
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_ch
    ckg_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk_src (clk_src),
      .rst     (rst),
      .hw_en   (hw_en[g]),
      .sw_en   (sw_en[g]),
      .clk_out (clk_out[g])
    );
  end
endmodule

// File: rtl/ckg_bank_chk.sv
module ckg_bank_chk
  import ckg_pkg::*;
#(
  parameter int unsigned N_OUT       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk_src,
  input logic             rst,
  input logic [N_OUT-1:0] hw_en,
  input logic [N_OUT-1:0] sw_en,
  input logic [N_OUT-1:0] clk_out
);
  localparam int unsigned LAG   = ckg_restart_lag(SYNC_STAGES);
  localparam int unsigned AGE_W = $clog2(LAG + 3) + 1;
  localparam int unsigned READY = LAG + 2;

  logic [AGE_W-1:0] age;

  always_ff @(negedge clk_src) begin
    if (rst)               age <= '0;
    else if (age < READY)  age <= age + 1'b1;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    logic [LAG-1:0] hist;

    always_ff @(negedge clk_src) begin
      if (rst) hist <= '0;
      else     hist <= {hist[LAG-2:0], hw_en[g] & sw_en[g]};
    end

    AST_RESET_CLOSED: assert property (@(negedge clk_src) disable iff (rst)
      $past(rst) |-> !clk_out[g]) else $error("reset gate open");  // R1

    AST_ONLY_WHEN_ENABLED: assert property (@(negedge clk_src) disable iff (rst)
      (age >= READY) && clk_out[g] |-> hist[LAG-1]) else $error("ran while disabled");  // R2

    AST_RESTART_ON_TIME: assert property (@(negedge clk_src) disable iff (rst)
      (age >= READY) && hist[LAG-1] |-> clk_out[g]) else $error("restart late");  // R7

    AST_LOW_WITH_SOURCE: assert property (@(posedge clk_src) disable iff (rst)
      !clk_out[g]) else $error("high while source low");  // R5
  end
endmodule

bind ckg_bank ckg_bank_chk #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_src (clk_src),
  .rst     (rst),
  .hw_en   (hw_en),
  .sw_en   (sw_en),
  .clk_out (clk_out)
);

// File: tb/sim_ckg_bank.sv
`timescale 1ns/1ps
module sim_ckg_bank;
  localparam int N   = 5;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] hw_en = '1;
  logic [N-1:0] sw_en = '1;
  logic [N-1:0] clk_out;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  int  rises [N];
  time first_rise [N];
  time last_rise [N];
  time last_fall [N];

  always #(PER/2) clk = ~clk;

  ckg_bank #(.N_OUT(N), .SYNC_STAGES(2)) u0 (
    .clk_src (clk),
    .rst     (rst),
    .hw_en   (hw_en),
    .sw_en   (sw_en),
    .clk_out (clk_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse-width monitors, one per output (R6)
  for (genvar g = 0; g < N; g++) begin : g_mon
    always @(posedge clk_out[g]) begin
      rises[g]++;
      if (first_rise[g] == 0) first_rise[g] = $time;
      if (last_fall[g] != 0)
        chk(((($time - last_fall[g]) % PER) == PER/2), "R6 low interval", $time - last_fall[g], PER/2);
      last_rise[g] = $time;
    end
    always @(negedge clk_out[g]) begin
      chk(($time - last_rise[g]) == PER/2, "R6 high pulse", $time - last_rise[g], PER/2);
      last_fall[g] = $time;
    end
  end

  task automatic clear_counts();
    for (int i = 0; i < N; i++) begin
      rises[i] = 0;
      first_rise[i] = 0;
    end
  endtask

  task automatic step_to_drive();   // just after a source rising edge
    @(posedge clk);
    #2;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    time t0;
    for (int i = 0; i < N; i++) begin
      last_rise[i] = 0;
      last_fall[i] = 0;
    end
    clear_counts();

    // R1: reset holds every gate shut although both enables are high
    wait_cycles(5);
    #2;
    chk(clk == 1'b1 && clk_out == '0, "R1 reset low", clk_out, 0);
    for (int i = 0; i < N; i++) chk(rises[i] == 0, "R1 no pulse in reset", rises[i], 0);

    // R1: first edge 3 periods after release
    step_to_drive();
    rst = 1'b0;
    t0 = $time;
    wait_cycles(6);
    for (int i = 0; i < N; i++)
      chk(first_rise[i] == t0 - 2 + 3*PER, "R1 first edge after reset", first_rise[i] - t0, 3*PER - 2);

    // R3: drop the pin of a running output, exactly 2 more edges
    step_to_drive();
    clear_counts();
    hw_en[0] = 1'b0;
    wait_cycles(8);
    chk(rises[0] == 2, "R3 edges after pin drop", rises[0], 2);
    chk(rises[2] == 8, "R8 neighbour unaffected", rises[2], 8);

    // R4: clear the register bit of a running output
    step_to_drive();
    clear_counts();
    sw_en[1] = 1'b0;
    wait_cycles(8);
    chk(rises[1] == 2, "R4 edges after bit clear", rises[1], 2);
    chk(rises[0] == 0, "R5 stopped stays quiet", rises[0], 0);
    #2;
    chk(clk == 1'b1 && clk_out[1:0] == 2'b00, "R5 stopped low in high phase", clk_out[1:0], 0);

    // R7: restart latency via the pin and via the register bit
    step_to_drive();
    clear_counts();
    t0 = $time;
    hw_en[0] = 1'b1;
    sw_en[1] = 1'b1;
    wait_cycles(8);
    for (int i = 0; i < 2; i++) begin
      chk(first_rise[i] - (t0 - 2) == 3*PER, "R7 restart edge", first_rise[i] - (t0 - 2), 3*PER);
      chk(first_rise[i] - (t0 - 2) >= 2*PER + PER && first_rise[i] - (t0 - 2) <= 7*PER,
          "R7 restart within 2..6 cycles of sampling", first_rise[i] - (t0 - 2), 3*PER);
    end

    // R2, R8: sweep every combination of the ten enable bits
    for (int p = 0; p < (1 << (2*N)); p++) begin
      logic [N-1:0] want;
      step_to_drive();
      hw_en = p[N-1:0];
      sw_en = p[2*N-1:N];
      want  = hw_en & sw_en;
      wait_cycles(3);
      clear_counts();
      wait_cycles(4);
      for (int i = 0; i < N; i++)
        chk(rises[i] == (want[i] ? 4 : 0), "R2 runs only with both enables", rises[i], want[i] ? 4 : 0);
      chk(clk_out == want, "R5 output level in high phase", clk_out, want);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule